// File: doc/BRIEF.md
# SPI Burst Transfer Sequencer

This block is the transfer engine of an SPI master. It takes 32-bit words from an external transmit FIFO and sends them out as one burst. The burst length in bits is programmable. Within each word, bytes leave lowest byte first, and within each byte the most significant bit goes first. The byte shifter is part of the block. It drives SCLK from a divider of the system clock and uses mode 0 timing, where data changes on the falling edge and is sampled on the rising edge. Each returned byte goes into the same byte lane of a receive word, and that word is pushed into an external receive FIFO.

A control write loads the following settings:
- an exchange bit,
- an immediate-start bit,
- a burst-length field,
- a channel select,
- a master-enable bit for each channel,
- a repeat-burst (wave) enable bit for each channel.

A transfer can start in three ways:
- a write of transmit data while immediate-start is set;
- immediate-start rising while the transmit FIFO holds data;
- the exchange bit rising while immediate-start is clear.

Normally the engine stops at the end of each burst. In repeat-burst mode it sets the exchange bit again and carries on with the next burst until the transmit FIFO runs dry.

The state machine has five states:
- IDLE: waits for a start.
- LOAD: pops a word. If the FIFO is empty it ends the transfer: it sets done, clears exchange and returns to IDLE. If no bits of the burst are left over, it reloads the burst count first.
- SEND: hands the next byte to the shifter.
- WAIT: waits for that byte to finish. It goes back to SEND while the word still has bits to send, and goes to STORE after the last byte of the word.
- STORE: pushes the receive word, or flags an overflow. It then goes either to LOAD (burst not finished, or repeat mode) or to IDLE (burst finished outside repeat mode).

Top module: `spi_burst_seq`

## Requirements
- R1: After reset, all chip selects are high, SCLK is low, and the done flag, overflow flag and exchange bit are all 0.
- R2: The burst is the burst-length field plus one bits. Each popped word supplies at most 32 of those bits. Bytes go out from bits [7:0] upward, most significant bit first. The remaining count drops by 8 after every byte.
- R3: Each received byte is stored in the byte lane of the word that matches its order of transfer. Lanes that were not transferred read 0. The word is pushed once its bytes are done.
- R4: If the receive FIFO is full when a word is ready, the word is dropped and the overflow flag is set. The flag stays set until `clr_ovf` is pulsed.
- R5: Outside repeat mode, the end of a burst sets done and stops the engine, even if transmit words remain. The exchange bit stays set while words remain.
- R6: Finding the transmit FIFO empty sets done and clears the exchange bit. An unfinished bit count is kept and is used up by the next start before the length field is reloaded.
- R7: Repeat mode applies when the selected channel is master, immediate-start is 0 and that channel's wave bit is 1. In this mode each new burst sets the exchange bit again, and bursts continue until the FIFO is empty.
- R8: A transfer starts in exactly these cases, and only when the selected channel is master:
  - a `txd_wr` pulse with immediate-start set;
  - immediate-start rising on a control write while the FIFO is non-empty;
  - the exchange bit rising on a control write with immediate-start 0.
- R9: A control write whose selected channel is master drives that channel's `cs_n` low and the others high. A control write to a non-master channel leaves `cs_n` unchanged.
- R10: SCLK idles low and has a period of 2*HALF_DIV system clocks. With the default of 2 this is 4 clocks.
- R11: While a transfer is running, start requests are ignored and are not remembered.
- R12: A `clr_done` pulse clears the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_xch | input | 1 | Exchange bit value written |
| ctrl_imm | input | 1 | Immediate-start bit value written |
| ctrl_len | input | LEN_W | Burst length minus one, in bits |
| ctrl_chan | input | CSEL_W | Selected channel |
| ctrl_master | input | NUM_CS | Per-channel master enables |
| ctrl_wave | input | NUM_CS | Per-channel repeat-burst enables |
| txd_wr | input | 1 | Pulse: a word was written to the transmit FIFO |
| clr_done | input | 1 | Clears the done flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 32 | Transmit FIFO head word |
| tx_pop | output | 1 | Pop the transmit FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Push `rx_data` into the receive FIFO |
| rx_data | output | 32 | Assembled receive word |
| xch_out | output | 1 | Current exchange bit |
| done_flag | output | 1 | Transfer-complete flag |
| ovf_flag | output | 1 | Receive-overflow flag |
| cs_n | output | NUM_CS | Active-low chip selects |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench checks the rounding of a burst that is not a whole number of bytes, such as 12 bits. A design that counted words instead of bytes would send too many bytes, or would leave stale data in the unused lanes of the receive word. It checks a burst that is longer than the data available followed by a start at a shorter length. A design that reloaded the length field there, instead of using the leftover count, would send one byte where four are expected. It also covers the start rules:
- an immediate-start edge with an empty FIFO must not start a transfer;
- an exchange edge while busy must not start a second transfer.

Other checks cover overflow with a full receive FIFO and the re-arming of the exchange bit in repeat mode. A design that restarted on those edges, or that pushed into a full FIFO, would show extra or missing words.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SEND,
        ST_WAIT,
        ST_STORE
    } seq_state_t;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bit_cnt;
    logic [7:0]       sh_tx;
    logic [7:0]       sh_rx;
    logic             tick;

    assign tick    = active && (cnt == CNT_LAST);
    assign mosi    = sh_tx[7];
    assign rx_byte = sh_rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            cnt       <= '0;
            bit_cnt   <= '0;
            sh_tx     <= '0;
            sh_rx     <= '0;
            sclk      <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    sh_tx   <= tx_byte;
                    cnt     <= '0;
                    bit_cnt <= '0;
                    sclk    <= 1'b0;
                end
            end else if (tick) begin
                cnt <= '0;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    sh_rx <= {sh_rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        sh_tx   <= {sh_tx[6:0], 1'b0};
                    end
                end
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assert_sclk_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sclk);
    assert_sclk_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> $stable(sclk));
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
    import spi_seq_pkg::*;
#(
    parameter int unsigned NUM_CS   = 4,
    parameter int unsigned LEN_W    = 12,
    parameter int unsigned HALF_DIV = 2,
    localparam int unsigned CSEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ctrl_xch,
    input  logic              ctrl_imm,
    input  logic [LEN_W-1:0]  ctrl_len,
    input  logic [CSEL_W-1:0] ctrl_chan,
    input  logic [NUM_CS-1:0] ctrl_master,
    input  logic [NUM_CS-1:0] ctrl_wave,
    input  logic              txd_wr,
    input  logic              clr_done,
    input  logic              clr_ovf,
    input  logic              tx_empty,
    input  logic [31:0]       tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [31:0]       rx_data,
    output logic              xch_out,
    output logic              done_flag,
    output logic              ovf_flag,
    output logic [NUM_CS-1:0] cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam int unsigned REM_W = LEN_W + 2;
    localparam logic signed [REM_W-1:0] REM_ZERO  = '0;
    localparam logic signed [REM_W-1:0] REM_BYTE  = REM_W'(BYTE_W);
    localparam logic signed [REM_W-1:0] REM_WORD  = REM_W'(WORD_W);
    localparam logic signed [6:0]       WL_BYTE   = 7'sd8;

    seq_state_t state, state_nx;

    logic              imm_q, xch_q;
    logic [LEN_W-1:0]  len_q;
    logic [CSEL_W-1:0] chan_q;
    logic [NUM_CS-1:0] master_q, wave_q;
    logic              done_q, ovf_q;
    logic [NUM_CS-1:0] cs_q;

    logic signed [REM_W-1:0] rem_q, rem_eff;
    logic signed [6:0]       word_left;
    logic [31:0]             word_sh, rx_acc;
    logic [1:0]              byte_idx;

    logic is_master, multi_mode, start_req, last_byte, burst_over;
    logic go, byte_done;
    logic [7:0] rx_byte;

    assign is_master  = master_q[chan_q];
    assign multi_mode = is_master && !imm_q && wave_q[chan_q];
    assign start_req  = (txd_wr && is_master && imm_q)
                     || (ctrl_wr && ctrl_master[ctrl_chan] && ctrl_imm && !imm_q && !tx_empty)
                     || (ctrl_wr && ctrl_master[ctrl_chan] && ctrl_xch && !xch_q && !ctrl_imm);
    assign rem_eff    = (rem_q > REM_ZERO) ? rem_q
                      : $signed({2'b00, len_q} + {{(REM_W-1){1'b0}}, 1'b1});
    assign last_byte  = (word_left <= WL_BYTE);
    assign burst_over = (rem_q <= REM_ZERO) && !multi_mode;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_req) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = tx_empty ? ST_IDLE : ST_SEND;
            ST_SEND:  state_nx = ST_WAIT;
            ST_WAIT:  if (byte_done) state_nx = last_byte ? ST_STORE : ST_SEND;
            ST_STORE: state_nx = burst_over ? ST_IDLE : ST_LOAD;
            default:  state_nx = ST_IDLE;
        endcase
    end

    assign tx_pop  = (state == ST_LOAD) && !tx_empty;
    assign rx_push = (state == ST_STORE) && !rx_full;
    assign go      = (state == ST_SEND);
    assign rx_data = rx_acc;

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imm_q     <= 1'b0;
            xch_q     <= 1'b0;
            len_q     <= '0;
            chan_q    <= '0;
            master_q  <= '0;
            wave_q    <= '0;
            done_q    <= 1'b0;
            ovf_q     <= 1'b0;
            cs_q      <= '1;
            rem_q     <= '0;
            word_left <= '0;
            word_sh   <= '0;
            rx_acc    <= '0;
            byte_idx  <= '0;
        end else begin
            if (clr_done) done_q <= 1'b0;
            if (clr_ovf)  ovf_q  <= 1'b0;
            if (ctrl_wr) begin
                imm_q    <= ctrl_imm;
                xch_q    <= ctrl_xch;
                len_q    <= ctrl_len;
                chan_q   <= ctrl_chan;
                master_q <= ctrl_master;
                wave_q   <= ctrl_wave;
                if (ctrl_master[ctrl_chan])
                    cs_q <= ~(NUM_CS'(1) << ctrl_chan);
            end
            unique case (state)
                ST_IDLE: ;
                ST_LOAD: begin
                    if (tx_empty) begin
                        done_q <= 1'b1;
                        xch_q  <= 1'b0;
                    end else begin
                        rem_q     <= rem_eff;
                        word_left <= (rem_eff > REM_WORD) ? 7'sd32 : rem_eff[6:0];
                        word_sh   <= tx_data;
                        rx_acc    <= '0;
                        byte_idx  <= '0;
                        if ((rem_q <= REM_ZERO) && multi_mode) xch_q <= 1'b1;
                    end
                end
                ST_SEND: ;
                ST_WAIT: begin
                    if (byte_done) begin
                        rx_acc[{byte_idx, 3'b000} +: 8] <= rx_byte;
                        byte_idx  <= byte_idx + 2'd1;
                        word_sh   <= {8'h00, word_sh[31:8]};
                        word_left <= word_left - WL_BYTE;
                        rem_q     <= rem_q - REM_BYTE;
                    end
                end
                ST_STORE: begin
                    if (rx_full) ovf_q <= 1'b1;
                    if (burst_over) begin
                        done_q <= 1'b1;
                        if (tx_empty) xch_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign xch_out   = xch_q;
    assign done_flag = done_q;
    assign ovf_flag  = ovf_q;
    assign cs_n      = cs_q;

    spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .tx_byte   (word_sh[7:0]),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    assert_cs_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_master[ctrl_chan]) |=> !cs_n[$past(ctrl_chan)]);
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && rx_full) |=> ovf_flag);
    assert_empty_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && tx_empty) |=> (!xch_out && done_flag && state == ST_IDLE));
    assert_pop_then_send_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> (state == ST_SEND));
    assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !byte_done) |=> (state == ST_WAIT));
endmodule

// File: tb/sim_spi_burst_seq.sv
module sim_spi_burst_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 0, ctrl_xch = 0, ctrl_imm = 0;
    logic [11:0] ctrl_len = '0;
    logic [1:0]  ctrl_chan = '0;
    logic [3:0]  ctrl_master = '0, ctrl_wave = '0;
    logic        txd_wr = 0, clr_done = 0, clr_ovf = 0;
    logic        tx_empty, tx_pop, rx_full = 0, rx_push;
    logic [31:0] tx_data, rx_data;
    logic        xch_out, done_flag, ovf_flag, sclk, mosi, miso;
    logic [3:0]  cs_n;
    logic        inv = 0;

    int total = 0, bad = 0;
    bit finished = 0;

    logic [31:0] txq [16];
    int wr_ptr = 0, rd_ptr = 0;
    logic [31:0] rxbuf [64];
    int rxn = 0;

    always #5 clk = ~clk;

    assign tx_empty = (wr_ptr == rd_ptr);
    assign tx_data  = txq[rd_ptr % 16];
    assign miso     = mosi ^ inv;

    always @(posedge clk) if (tx_pop) rd_ptr <= rd_ptr + 1;
    always @(posedge clk) if (rx_push) begin rxbuf[rxn % 64] <= rx_data; rxn <= rxn + 1; end

    spi_burst_seq u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_xch(ctrl_xch), .ctrl_imm(ctrl_imm),
        .ctrl_len(ctrl_len), .ctrl_chan(ctrl_chan), .ctrl_master(ctrl_master), .ctrl_wave(ctrl_wave),
        .txd_wr(txd_wr), .clr_done(clr_done), .clr_ovf(clr_ovf), .tx_empty(tx_empty),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
        .xch_out(xch_out), .done_flag(done_flag), .ovf_flag(ovf_flag), .cs_n(cs_n),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    typedef struct packed {
        logic [11:0] len;
        logic [31:0] w0;
        logic [31:0] w1;
        logic        inv;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{12'd7,  32'h000000A5, 32'h11111111, 1'b0},
        '{12'd31, 32'h12345678, 32'h9ABCDEF0, 1'b0},
        '{12'd63, 32'hCAFEF00D, 32'h0BADBEEF, 1'b0},
        '{12'd11, 32'h00C0FFEE, 32'h55AA55AA, 1'b1},
        '{12'd39, 32'hDEADB00B, 32'h000000E7, 1'b1},
        '{12'd95, 32'h01020304, 32'hA0B0C0D0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ctrl(input logic xch, input logic imm, input logic [11:0] len,
                        input logic [1:0] chan, input logic [3:0] mst, input logic [3:0] wav);
        @(negedge clk);
        ctrl_xch = xch; ctrl_imm = imm; ctrl_len = len; ctrl_chan = chan;
        ctrl_master = mst; ctrl_wave = wav; ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic txw(input logic [31:0] w, input bit pulse);
        @(negedge clk);
        txq[wr_ptr % 16] = w;
        wr_ptr = wr_ptr + 1;
        if (pulse) begin
            txd_wr = 1'b1;
            @(negedge clk);
            txd_wr = 1'b0;
        end
    endtask

    task automatic pulse_clr_done();
        @(negedge clk); clr_done = 1'b1; @(negedge clk); clr_done = 1'b0;
    endtask

    task automatic wait_done(input int max);
        for (int i = 0; i < max && !done_flag; i++) @(negedge clk);
        cycles(2);
    endtask

    task automatic flush_tx();
        @(negedge clk); wr_ptr = rd_ptr;
    endtask

    initial begin
        int base, rem, nb, wb, pushes, n;
        logic [31:0] w, m, e;
        cycles(3);
        // R1 reset state
        check(cs_n == 4'hF, "R1 cs_n", {28'd0, cs_n}, 32'hF);
        check(!done_flag && !ovf_flag && !xch_out, "R1 flags", {29'd0, done_flag, ovf_flag, xch_out}, 0);
        check(sclk == 1'b0, "R1 sclk", {31'd0, sclk}, 0);
        rst_n = 1'b1;
        cycles(2);

        // R9 chip selects
        ctrl(0, 0, 12'd7, 2'd2, 4'hF, 4'h0);
        cycles(1);
        check(cs_n == 4'b1011, "R9 master chan2", {28'd0, cs_n}, 32'hB);
        ctrl(0, 0, 12'd7, 2'd1, 4'b0100, 4'h0);
        cycles(1);
        check(cs_n == 4'b1011, "R9 non-master write", {28'd0, cs_n}, 32'hB);

        // table of bursts, exchange start, R2 R3 R5 R6
        foreach (VEC[k]) begin
            flush_tx();
            pulse_clr_done();
            inv = VEC[k].inv;
            ctrl(0, 0, VEC[k].len, 2'd0, 4'hF, 4'h0);
            txw(VEC[k].w0, 0);
            txw(VEC[k].w1, 0);
            base = rxn;
            ctrl(1, 0, VEC[k].len, 2'd0, 4'hF, 4'h0);
            wait_done(2000);
            rem = int'(VEC[k].len) + 1;
            pushes = 0;
            for (int j = 0; j < 2; j++) begin
                w = (j == 0) ? VEC[k].w0 : VEC[k].w1;
                wb = (rem > 32) ? 32 : rem;
                nb = (wb + 7) / 8;
                m = (nb >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 32'd1);
                e = (VEC[k].inv ? ~w : w) & m;
                check(rxbuf[(base + j) % 64] == e, "R2 R3 rx word", rxbuf[(base + j) % 64], e);
                rem -= 8 * nb;
                pushes++;
                if (rem <= 0) break;
            end
            check(rxn - base == pushes, "R5 push count", rxn - base, pushes);
            check(wr_ptr - rd_ptr == 2 - pushes, "R5 words left", wr_ptr - rd_ptr, 2 - pushes);
            check(xch_out == (pushes < 2), "R6 exchange bit", {31'd0, xch_out}, {31'd0, pushes < 2});
            check(done_flag, "R5 done", {31'd0, done_flag}, 1);
        end
        inv = 0;

        // R6 leftover bits carried over: 32 bits remain, length field now 8
        pulse_clr_done();
        check(!done_flag, "R12 clear done", {31'd0, done_flag}, 0);
        ctrl(0, 0, 12'd7, 2'd0, 4'hF, 4'h0);
        txw(32'hFFEEDDCC, 0);
        base = rxn;
        ctrl(1, 0, 12'd7, 2'd0, 4'hF, 4'h0);
        wait_done(2000);
        check(rxn - base == 1 && rxbuf[base % 64] == 32'hFFEEDDCC, "R6 leftover burst",
              rxbuf[base % 64], 32'hFFEEDDCC);

        // R8 immediate start: rise with empty FIFO does nothing
        pulse_clr_done();
        flush_tx();
        base = rxn;
        ctrl(0, 1, 12'd7, 2'd0, 4'hF, 4'h0);
        cycles(100);
        check(rxn == base && !done_flag, "R8 imm rise empty", rxn - base, 0);
        txw(32'h0000003C, 1);
        wait_done(2000);
        check(rxn - base == 1 && rxbuf[base % 64] == 32'h3C, "R8 start on tx write",
              rxbuf[base % 64], 32'h3C);
        pulse_clr_done();
        ctrl(0, 0, 12'd7, 2'd0, 4'hF, 4'h0);
        txw(32'h0000005A, 0);
        base = rxn;
        cycles(50);
        check(rxn == base, "R8 no start without trigger", rxn - base, 0);
        ctrl(0, 1, 12'd7, 2'd0, 4'hF, 4'h0);
        wait_done(2000);
        check(rxn - base == 1 && rxbuf[base % 64] == 32'h5A, "R8 start on imm rise",
              rxbuf[base % 64], 32'h5A);

        // R4 overflow
        pulse_clr_done();
        flush_tx();
        rx_full = 1'b1;
        ctrl(0, 0, 12'd7, 2'd0, 4'hF, 4'h0);
        txw(32'h77, 0);
        base = rxn;
        ctrl(1, 0, 12'd7, 2'd0, 4'hF, 4'h0);
        wait_done(2000);
        check(rxn == base, "R4 no push when full", rxn - base, 0);
        check(ovf_flag, "R4 overflow set", {31'd0, ovf_flag}, 1);
        rx_full = 1'b0;
        @(negedge clk); clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0;
        check(!ovf_flag, "R4 overflow cleared", {31'd0, ovf_flag}, 0);

        // R7 repeat mode: bursts of 8 bits over three words, exchange re-armed
        pulse_clr_done();
        ctrl(0, 0, 12'd7, 2'd0, 4'hF, 4'h1);
        txw(32'h11, 0); txw(32'h22, 0); txw(32'h33, 0);
        base = rxn;
        ctrl(1, 0, 12'd7, 2'd0, 4'hF, 4'h1);
        for (int i = 0; i < 2000 && rxn - base < 1; i++) @(negedge clk);
        cycles(8);
        ctrl(0, 0, 12'd7, 2'd0, 4'hF, 4'h1);
        cycles(1);
        check(!xch_out, "R7 exchange written low", {31'd0, xch_out}, 0);
        for (int i = 0; i < 2000 && rxn - base < 2; i++) @(negedge clk);
        cycles(3);
        check(xch_out, "R7 exchange re-armed", {31'd0, xch_out}, 1);
        wait_done(2000);
        check(rxn - base == 3 && rxbuf[(base + 2) % 64] == 32'h33, "R7 all words sent",
              rxn - base, 3);
        check(!xch_out, "R7 exchange cleared at empty", {31'd0, xch_out}, 0);

        // R10 SCLK period and R11 busy ignores starts
        pulse_clr_done();
        ctrl(0, 0, 12'd31, 2'd0, 4'hF, 4'h0);
        txw(32'hA1B2C3D4, 0); txw(32'h0, 0);
        base = rxn;
        ctrl(1, 0, 12'd31, 2'd0, 4'hF, 4'h0);
        for (int i = 0; i < 200 && !sclk; i++) @(negedge clk);
        n = 0;
        for (int i = 0; i < 50 && sclk; i++) begin @(negedge clk); n++; end
        for (int i = 0; i < 50 && !sclk; i++) begin @(negedge clk); n++; end
        check(n == 4, "R10 sclk period", n, 4);
        ctrl(0, 0, 12'd31, 2'd0, 4'hF, 4'h0);
        ctrl(1, 0, 12'd31, 2'd0, 4'hF, 4'h0);
        wait_done(2000);
        cycles(300);
        check(rxn - base == 1 && wr_ptr - rd_ptr == 1, "R11 start ignored while busy",
              rxn - base, 1);
        check(rxbuf[base % 64] == 32'hA1B2C3D4, "R2 full word", rxbuf[base % 64], 32'hA1B2C3D4);
        check(!sclk, "R10 sclk idle low", {31'd0, sclk}, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule